// File: doc/BRIEF.md
# Bus Master Tenure Controller with Latency Timer

This block governs how long a bus-master-capable device keeps a shared parallel bus. When the local transfer engine wants the bus, the block raises a bus request to the external arbiter. When the grant comes back, it takes ownership and enables the data path. At the same moment it arms a countdown from a software-programmed 8-bit reload value. The countdown drops by one on every clock of tenure. When it runs out, the device must give the bus back, so that no single master can starve the others of bandwidth.

Expiry always removes the data-path enable for one clock and pulses an expiry strobe. What follows depends on the other masters. If some other master is waiting, the block withdraws its request for a clock before asking again. If no other master is waiting, the block keeps its request up and takes the bus straight back on the next grant. If the engine finishes before the timer runs out, the block gives the bus up quietly and raises no strobe. Arbitration, address decoding and data-phase signalling belong to other blocks.

Top module: `busTenureCtl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `busReq`, `busOwned`, `xferEn` and `expiryStrobe` low from the following clock onward, until a new request arrives.
- R2: With the block idle, `engineReq` high at a clock edge makes `busReq` high after that edge.
- R3: `busOwned` and `xferEn` go high only at the edge after `busGrant` is seen while `busReq` is high. They are always equal.
- R4: While the engine keeps requesting, one tenure lasts exactly `latencyVal + 1` clocks. `latencyVal` is sampled at the grant edge.
- R5: A reload value of 0 gives a tenure of exactly one clock.
- R6: On expiry, `expiryStrobe` is high for exactly one clock, and that is the first clock in which `xferEn` is low after the tenure.
- R7: If `othersWaiting` is high during the strobe clock, `busReq` is low for the next clock. It then rises again if the engine still requests.
- R8: If `othersWaiting` is low and `busGrant` is high during the strobe clock, `busOwned` is high again in the next clock, with a freshly armed timer.
- R9: If `engineReq` falls during a tenure, ownership ends at the next edge and no strobe is raised.
- R10: If `engineReq` falls while the block is requesting but not yet granted, `busReq` is low after the next edge.
- R11: A change of `latencyVal` during a tenure does not alter the length of that tenure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| latencyVal | input | 8 | Programmed reload value of the tenure timer |
| engineReq | input | 1 | Transfer engine wants the bus (held until done) |
| busGrant | input | 1 | Grant from the bus arbiter |
| othersWaiting | input | 1 | Another master is requesting the bus |
| busReq | output | 1 | Request to the arbiter |
| busOwned | output | 1 | Device currently owns the bus |
| expiryStrobe | output | 1 | One-clock pulse on timer expiry |
| xferEn | output | 1 | Enable to the data path |

## Verification
The hardest situations to reach are the two branches at the moment of expiry: backing off when another master waits, and reclaiming at once when none does. To reach them, the engine request must be held for a whole tenure while the grant and the waiting flag are set exactly in the strobe clock. Directed sequences place the grant and the waiting flag in that clock for both outcomes, with reload values of 0 and 3. Another directed sequence rewrites the reload value in the middle of a tenure. A long biased random run then crosses early release with expiry, and every clock is compared with a behavioural model.

// File: rtl/busTenurePkg.sv
package busTenurePkg;

  // Ownership lifecycle phases
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_ASK     = 3'd1,
    PH_OWN     = 3'd2,
    PH_EXPIRE  = 3'd3,
    PH_BACKOFF = 3'd4
  } phaseT;

  // Strobes from control to timer datapath
  typedef struct packed {
    logic loadCnt;
    logic decCnt;
  } timerCtlT;

endpackage

// File: rtl/tenureTimer.sv
module tenureTimer
  import busTenurePkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] reloadVal,
  input  timerCtlT         ctl,
  output logic             cntZero
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] remaining;

  // The timer sits at its reload value whenever it is not counting.
  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= reloadVal;
    end else if (ctl.loadCnt) begin
      remaining <= reloadVal;
    end else if (ctl.decCnt) begin
      remaining <= remaining - ONE;
    end
  end

  assign cntZero = (remaining == '0);

endmodule

// File: rtl/tenureCtrl.sv
module tenureCtrl
  import busTenurePkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     engineReq,
  input  logic     busGrant,
  input  logic     othersWaiting,
  input  logic     cntZero,
  output timerCtlT timerCtl,
  output logic     busReq,
  output logic     busOwned,
  output logic     expiryStrobe,
  output logic     xferEn
);

  phaseT phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: begin
        if (engineReq) phaseNext = PH_ASK;
      end
      PH_ASK: begin
        if (!engineReq)    phaseNext = PH_IDLE;
        else if (busGrant) phaseNext = PH_OWN;
      end
      PH_OWN: begin
        if (!engineReq)   phaseNext = PH_IDLE;
        else if (cntZero) phaseNext = PH_EXPIRE;
      end
      PH_EXPIRE: begin
        if (!engineReq)         phaseNext = PH_IDLE;
        else if (othersWaiting) phaseNext = PH_BACKOFF;
        else if (busGrant)      phaseNext = PH_OWN;
        else                    phaseNext = PH_ASK;
      end
      PH_BACKOFF: begin
        phaseNext = engineReq ? PH_ASK : PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phaseNext;
  end

  // Timer strobes: count only while owning, rearm otherwise
  always_comb begin
    timerCtl.loadCnt = (phase != PH_OWN);
    timerCtl.decCnt  = (phase == PH_OWN) && !cntZero;
  end

  // Moore outputs decoded from the phase register
  always_comb begin
    busReq       = (phase == PH_ASK) || (phase == PH_OWN) || (phase == PH_EXPIRE);
    busOwned     = (phase == PH_OWN);
    xferEn       = (phase == PH_OWN);
    expiryStrobe = (phase == PH_EXPIRE);
  end

endmodule

// File: rtl/busTenureCtl.sv
module busTenureCtl
  import busTenurePkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] latencyVal,
  input  logic             engineReq,
  input  logic             busGrant,
  input  logic             othersWaiting,
  output logic             busReq,
  output logic             busOwned,
  output logic             expiryStrobe,
  output logic             xferEn
);

  timerCtlT timerCtl;
  logic     cntZero;

  tenureCtrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .engineReq    (engineReq),
    .busGrant     (busGrant),
    .othersWaiting(othersWaiting),
    .cntZero      (cntZero),
    .timerCtl     (timerCtl),
    .busReq       (busReq),
    .busOwned     (busOwned),
    .expiryStrobe (expiryStrobe),
    .xferEn       (xferEn)
  );

  tenureTimer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .reloadVal(latencyVal),
    .ctl      (timerCtl),
    .cntZero  (cntZero)
  );

endmodule

// File: rtl/tenureChecker.sv
module tenureChecker (
  input logic clk,
  input logic rst,
  input logic engineReq,
  input logic busGrant,
  input logic othersWaiting,
  input logic busReq,
  input logic busOwned,
  input logic expiryStrobe,
  input logic xferEn
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!busReq && !busOwned && !expiryStrobe && !xferEn)); // R1

  AST_GRANT_BEFORE_OWN: assert property (@(posedge clk) disable iff (rst)
    $rose(busOwned) |-> ($past(busGrant) && $past(busReq))); // R3

  AST_ENABLE_TRACKS_OWN: assert property (@(posedge clk) disable iff (rst)
    $rose(xferEn) |-> busOwned); // R3

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    expiryStrobe |=> !expiryStrobe); // R6

  AST_STROBE_AT_DROP: assert property (@(posedge clk) disable iff (rst)
    $rose(expiryStrobe) |-> (!xferEn && $past(xferEn))); // R6

  AST_BACKOFF_DROP: assert property (@(posedge clk) disable iff (rst)
    (expiryStrobe && othersWaiting) |=> !busReq); // R7

  AST_RECLAIM: assert property (@(posedge clk) disable iff (rst)
    (expiryStrobe && !othersWaiting && busGrant && engineReq) |=> busOwned); // R8

  AST_QUIET_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busOwned && !engineReq) |=> (!busOwned && !expiryStrobe)); // R9

  AST_CANCEL_ASK: assert property (@(posedge clk) disable iff (rst)
    (busReq && !busOwned && !expiryStrobe && !engineReq) |=> !busReq); // R10

endmodule

bind busTenureCtl tenureChecker u_chk (
  .clk          (clk),
  .rst          (rst),
  .engineReq    (engineReq),
  .busGrant     (busGrant),
  .othersWaiting(othersWaiting),
  .busReq       (busReq),
  .busOwned     (busOwned),
  .expiryStrobe (expiryStrobe),
  .xferEn       (xferEn)
);

// File: tb/busTenureCtl_tb.sv
module busTenureCtl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] latencyVal;
  logic       engineReq, busGrant, othersWaiting;
  logic       busReq, busOwned, expiryStrobe, xferEn;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit compareOn = 0;

  // model state
  int mPhase = 0;   // 0 idle, 1 asking, 2 owning, 3 expired, 4 backing off
  int mLeft  = 0;

  busTenureCtl u_dut (
    .clk(clk), .rst(rst), .latencyVal(latencyVal), .engineReq(engineReq),
    .busGrant(busGrant), .othersWaiting(othersWaiting), .busReq(busReq),
    .busOwned(busOwned), .expiryStrobe(expiryStrobe), .xferEn(xferEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
    end
  endtask

  // Behavioural reference model, updated on each rising edge
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mPhase = 0;
    end else begin
      case (mPhase)
        0: if (engineReq) mPhase = 1;
        1: if (!engineReq) mPhase = 0;
           else if (busGrant) begin mPhase = 2; mLeft = latencyVal; end
        2: if (!engineReq) mPhase = 0;
           else if (mLeft == 0) mPhase = 3;
           else mLeft = mLeft - 1;
        3: if (!engineReq) mPhase = 0;
           else if (othersWaiting) mPhase = 4;
           else if (busGrant) begin mPhase = 2; mLeft = latencyVal; end
           else mPhase = 1;
        default: mPhase = engineReq ? 1 : 0;
      endcase
    end
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired: actual %0d expected %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (compareOn) begin
      chk(busReq == (mPhase >= 1 && mPhase <= 3), "R2 busReq", busReq, (mPhase >= 1 && mPhase <= 3));
      chk(busOwned == (mPhase == 2), "R3 busOwned", busOwned, mPhase == 2);
      chk(xferEn == (mPhase == 2), "R3 xferEn", xferEn, mPhase == 2);
      chk(expiryStrobe == (mPhase == 3), "R6 expiryStrobe", expiryStrobe, mPhase == 3);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setIn(input bit er, input bit g, input bit ow);
    engineReq = er; busGrant = g; othersWaiting = ow;
  endtask

  // Holds the engine request and grant; counts the owned clocks of one tenure
  task automatic tenureLen(output int len);
    len = 0;
    while (!busOwned) step(1);
    while (busOwned) begin len++; step(1); end
  endtask

  initial begin
    int len;
    rst = 1'b1; latencyVal = 8'd3; setIn(0, 0, 0);
    step(2);
    rst = 1'b0;
    step(1);
    chk(!busReq && !busOwned && !xferEn && !expiryStrobe, "R1 reset state", {busReq, busOwned, xferEn, expiryStrobe}, 0);
    compareOn = 1;

    // R2: request rises one clock after engine request
    setIn(1, 0, 0); step(1);
    chk(busReq == 1, "R2 request raised", busReq, 1);
    chk(busOwned == 0, "R3 no ownership without grant", busOwned, 0);
    // R3: grant gives ownership at next edge
    busGrant = 1; step(1);
    chk(busOwned && xferEn, "R3 ownership after grant", busOwned, 1);
    // R4: tenure of latencyVal+1 = 4 clocks (one already seen)
    len = 1;
    while (busOwned) begin step(1); if (busOwned) len++; end
    chk(len == 4, "R4 tenure length L=3", len, 4);
    // R6: strobe now, enable low
    chk(expiryStrobe && !xferEn, "R6 strobe with enable drop", expiryStrobe, 1);
    // R8: no waiter, grant held -> reclaim next clock
    step(1);
    chk(busOwned == 1, "R8 immediate reclaim", busOwned, 1);
    chk(expiryStrobe == 0, "R6 strobe one clock", expiryStrobe, 0);

    // R7: others waiting at next expiry -> request withdrawn
    othersWaiting = 1;
    while (!expiryStrobe) step(1);
    step(1);
    chk(busReq == 0, "R7 request withdrawn", busReq, 0);
    step(1);
    chk(busReq == 1, "R7 request returns", busReq, 1);
    othersWaiting = 0;

    // R5: zero reload -> one clock tenure
    setIn(0, 0, 0); step(2);
    latencyVal = 8'd0;
    setIn(1, 1, 0);
    tenureLen(len);
    chk(len == 1, "R5 zero reload single clock", len, 1);
    chk(expiryStrobe == 1, "R6 strobe after zero tenure", expiryStrobe, 1);

    // R11: reload change mid-tenure has no effect
    setIn(0, 0, 0); step(2);
    latencyVal = 8'd5;
    setIn(1, 1, 0);
    while (!busOwned) step(1);
    busGrant = 0; latencyVal = 8'd1;
    len = 0;
    while (busOwned) begin len++; step(1); end
    chk(len == 6, "R11 tenure unchanged by rewrite", len, 6);

    // R9: engine finishes early -> quiet release
    setIn(0, 0, 0); step(2);
    latencyVal = 8'd10;
    setIn(1, 1, 0);
    while (!busOwned) step(1);
    step(2);
    engineReq = 0; step(1);
    chk(busOwned == 0, "R9 early release", busOwned, 0);
    chk(expiryStrobe == 0, "R9 no strobe on early release", expiryStrobe, 0);

    // R10: cancel while requesting
    setIn(1, 0, 0); step(1);
    chk(busReq == 1, "R10 asking", busReq, 1);
    engineReq = 0; step(1);
    chk(busReq == 0, "R10 request cancelled", busReq, 0);

    // Biased random run compared every clock
    for (int i = 0; i < 3000; i++) begin
      engineReq     = ($urandom % 10) < 8;
      busGrant      = ($urandom % 2) == 1;
      othersWaiting = ($urandom % 10) < 3;
      if (($urandom % 16) == 0) latencyVal = 8'($urandom % 8);
      step(1);
    end

    // R1: reset mid-activity
    setIn(1, 1, 0); step(3);
    rst = 1'b1; step(1);
    setIn(0, 0, 0); rst = 1'b0; step(1);
    chk(!busReq && !busOwned && !expiryStrobe && !xferEn, "R1 reset mid-tenure", {busReq, busOwned, expiryStrobe, xferEn}, 0);

    compareOn = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule